// File: doc/BRIEF.md
# Masked Pattern Match Trigger Unit

This unit watches a wide monitored data bus and compares each accepted sample against two independent sets of reference words. The first set, a value and a mask, raises a trigger. The second set, also a value and a mask, qualifies a trace pattern. Software loads every reference word through a 32-bit word-write port. A small control word picks the pattern comparison style and decides which events also ask for a timestamp.

Samples arrive on a valid/ready stream. The unit never applies back-pressure: `smp_ready` goes high on the first clock edge after reset and stays high. A sample is consumed on every clock edge where `smp_valid` and `smp_ready` are both high. No data is stored for later, so a sender may hold `smp_valid` high as long as it likes.

The trigger path always compares values and reports only the start of a match. The pattern path can compare values or look for changes in the masked bits since the previous accepted sample. All three outputs are registered. Each output is high for the one cycle that follows the accepted sample that caused it.

Top module: `ptu_top`

## Requirements
- R1: While reset is asserted and after it is released, all reference words and the control word are zero. `trig_pulse`, `pat_hit` and `ts_req` are low until the first sample is accepted.
- R2: A write with address bit 5 clear stores `cfg_wdata` in one reference word. Address bits [4:3] pick the array: 0 trigger value, 1 trigger mask, 2 pattern value, 3 pattern mask. Address bits [2:0] pick word k, which covers sample bits [32k+31:32k]. Word 0 holds the least significant bits.
- R3: A write with address bit 5 set loads the control word. Bit 0 is the pattern mode (0 value, 1 toggle). Bit 1 enables a timestamp on pattern hits. Bit 2 enables a timestamp on triggers.
- R4: A mask bit of 1 makes that sample bit take part in a comparison. Bits whose mask bit is 0 never affect a result. In value mode, an all-zero mask matches every accepted sample.
- R5: `trig_pulse` is high for exactly one cycle, the cycle after an accepted sample whose masked bits equal the trigger value while the previous accepted sample did not match.
- R6: After a trigger, `trig_pulse` does not fire again until an accepted sample fails to match. Cycles without an accepted sample neither clear nor set this state.
- R7: In value mode, `pat_hit` is high in the cycle after every accepted sample whose masked bits equal the pattern value.
- R8: In toggle mode, `pat_hit` is high in the cycle after an accepted sample in which any masked bit differs from the previous accepted sample. The first sample accepted after reset never hits.
- R9: `ts_req` is high in the same cycle as `trig_pulse` when control bit 2 is set, and in the same cycle as `pat_hit` when control bit 1 is set. It is low otherwise.
- R10: A cycle with `smp_valid` low is followed by a cycle with all three outputs low.
- R11: A register write in the same cycle as an accepted sample takes effect from the next accepted sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, high from the first edge after reset |
| smp_data | input | 256 | Monitored bus sample |
| trig_pulse | output | 1 | One-cycle trigger on the start of a match |
| pat_hit | output | 1 | Pattern qualification, one cycle per hit |
| ts_req | output | 1 | Timestamp request |

## Verification
The assertions assume that `smp_valid` and the write port carry known values whenever reset is released. They also assume that a control write changes the timestamp enables only through the register path, so that the enable seen one cycle earlier explains `ts_req`. The bench drives every input on the falling clock edge and holds it for a whole cycle. It samples the outputs on the next falling edge. Idle cycles are placed between samples so that the quiet-cycle rule is exercised over and over without breaking the assertions' view of when a sample was accepted.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  typedef enum logic [1:0] {
    SEL_TRIG_VAL = 2'd0,
    SEL_TRIG_MSK = 2'd1,
    SEL_PAT_VAL  = 2'd2,
    SEL_PAT_MSK  = 2'd3
  } arr_sel_e;

  localparam int CTL_W        = 3;
  localparam int CTL_TOGGLE   = 0;
  localparam int CTL_PAT_TS   = 1;
  localparam int CTL_TRIG_TS  = 2;
endpackage

// File: rtl/ptu_regs.sv
module ptu_regs
  import ptu_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int WORD_W = 32,
  localparam int NWORDS = DATA_W / WORD_W,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ADDR_W = WIDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [DATA_W-1:0] trig_val,
  output logic [DATA_W-1:0] trig_msk,
  output logic [DATA_W-1:0] pat_val,
  output logic [DATA_W-1:0] pat_msk,
  output logic [CTL_W-1:0]  ctl
);
  logic              is_ctl;
  arr_sel_e          sel;
  logic [WIDX_W-1:0] widx;

  assign is_ctl = addr[ADDR_W-1];
  assign sel    = arr_sel_e'(addr[ADDR_W-2 -: 2]);
  assign widx   = addr[WIDX_W-1:0];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic hit_w;
    assign hit_w = we && !is_ctl && (widx == WIDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_val[w*WORD_W +: WORD_W] <= '0;
        trig_msk[w*WORD_W +: WORD_W] <= '0;
        pat_val[w*WORD_W +: WORD_W]  <= '0;
        pat_msk[w*WORD_W +: WORD_W]  <= '0;
      end else if (hit_w) begin
        case (sel)
          SEL_TRIG_VAL: trig_val[w*WORD_W +: WORD_W] <= wdata;
          SEL_TRIG_MSK: trig_msk[w*WORD_W +: WORD_W] <= wdata;
          SEL_PAT_VAL:  pat_val[w*WORD_W +: WORD_W]  <= wdata;
          default:      pat_msk[w*WORD_W +: WORD_W]  <= wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctl <= '0;
    else if (we && is_ctl) ctl <= wdata[CTL_W-1:0];
  end
endmodule

// File: rtl/ptu_match.sv
module ptu_match #(
  parameter int DATA_W = 256,
  parameter int WORD_W = 32,
  localparam int NWORDS = DATA_W / WORD_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] prev,
  input  logic [DATA_W-1:0] ref_val,
  input  logic [DATA_W-1:0] ref_msk,
  input  logic              toggle,
  output logic              hit
);
  logic [NWORDS-1:0] word_eq;
  logic [NWORDS-1:0] word_chg;

  for (genvar w = 0; w < NWORDS; w++) begin : g_cmp
    logic [WORD_W-1:0] d, p, v, m;
    assign d = data[w*WORD_W +: WORD_W];
    assign p = prev[w*WORD_W +: WORD_W];
    assign v = ref_val[w*WORD_W +: WORD_W];
    assign m = ref_msk[w*WORD_W +: WORD_W];
    assign word_eq[w]  = ((d ^ v) & m) == '0;
    assign word_chg[w] = |((d ^ p) & m);
  end

  assign hit = toggle ? (|word_chg) : (&word_eq);
endmodule

// File: rtl/ptu_top.sv
module ptu_top
  import ptu_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int WORD_W = 32,
  localparam int NWORDS = DATA_W / WORD_W,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ADDR_W = WIDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              trig_pulse,
  output logic              pat_hit,
  output logic              ts_req
);
  logic [DATA_W-1:0] trig_val, trig_msk, pat_val, pat_msk;
  logic [CTL_W-1:0]  ctl;
  logic              pat_toggle, pat_ts_en, trig_ts_en;

  logic [DATA_W-1:0] prev_q;
  logic              have_prev_q;
  logic              trig_hold_q;
  logic              ready_q;
  logic              accept;
  logic              trig_raw, pat_raw;
  logic              trig_fire, pat_fire;

  ptu_regs #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .trig_val(trig_val), .trig_msk(trig_msk),
    .pat_val(pat_val), .pat_msk(pat_msk), .ctl(ctl)
  );

  assign pat_toggle = ctl[CTL_TOGGLE];
  assign pat_ts_en  = ctl[CTL_PAT_TS];
  assign trig_ts_en = ctl[CTL_TRIG_TS];

  ptu_match #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_trig_cmp (
    .data(smp_data), .prev(prev_q), .ref_val(trig_val), .ref_msk(trig_msk),
    .toggle(1'b0), .hit(trig_raw)
  );

  ptu_match #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_pat_cmp (
    .data(smp_data), .prev(prev_q), .ref_val(pat_val), .ref_msk(pat_msk),
    .toggle(pat_toggle), .hit(pat_raw)
  );

  assign smp_ready = ready_q;
  assign accept    = smp_valid && ready_q;
  assign trig_fire = trig_raw && !trig_hold_q;
  assign pat_fire  = pat_raw && (!pat_toggle || have_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      trig_hold_q <= 1'b0;
      trig_pulse  <= 1'b0;
      pat_hit     <= 1'b0;
      ts_req      <= 1'b0;
    end else begin
      ready_q    <= 1'b1;
      trig_pulse <= accept && trig_fire;
      pat_hit    <= accept && pat_fire;
      ts_req     <= accept && ((trig_fire && trig_ts_en) || (pat_fire && pat_ts_en));
      if (accept) begin
        prev_q      <= smp_data;
        have_prev_q <= 1'b1;
        trig_hold_q <= trig_raw;
      end
    end
  end
endmodule

// File: rtl/ptu_checker.sv
module ptu_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic trig_pulse,
  input logic pat_hit,
  input logic ts_req,
  input logic trig_ts_en,
  input logic pat_ts_en
);
  a_r9_ts_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ts_req |-> (trig_pulse || pat_hit));

  a_r5_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!trig_pulse && !pat_hit && !ts_req));

  a_r9_trig_stamped: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(trig_ts_en)) |-> ts_req);

  a_r9_pat_stamped: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_hit && $past(pat_ts_en)) |-> ts_req);
endmodule

bind ptu_top ptu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
  .trig_pulse(trig_pulse), .pat_hit(pat_hit), .ts_req(ts_req),
  .trig_ts_en(trig_ts_en), .pat_ts_en(pat_ts_en)
);

// File: tb/tb_ptu_top.sv
`timescale 1ns/1ps
module tb_ptu_top;
  localparam int DATA_W = 256;
  localparam int WORD_W = 32;
  localparam logic [5:0] A_CTL = 6'h20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [5:0]        cfg_addr = '0;
  logic [WORD_W-1:0] cfg_wdata = '0;
  logic              smp_valid = 1'b0;
  logic              smp_ready;
  logic [DATA_W-1:0] smp_data = '0;
  logic              trig_pulse, pat_hit, ts_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptu_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .trig_pulse(trig_pulse), .pat_hit(pat_hit),
    .ts_req(ts_req)
  );

  localparam logic [DATA_W-1:0] BG = {8{32'hC0DE_0000}};
  localparam logic [DATA_W-1:0] TRIG_HIT = BG | (256'h1234 << 64);

  task automatic check(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    smp_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk) cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk) cfg_we = 1'b0;
  endtask

  function automatic logic [5:0] aw(input int sel, input int w);
    return 6'((sel << 3) | w);
  endfunction

  task automatic send(input logic [DATA_W-1:0] d, output logic t, output logic p, output logic s);
    @(negedge clk) smp_valid = 1'b1; smp_data = d;
    @(negedge clk) smp_valid = 1'b0;
    t = trig_pulse; p = pat_hit; s = ts_req;
  endtask

  task automatic t_reset();
    check("R1", "trig after reset", trig_pulse, 1'b0);
    check("R1", "pat after reset", pat_hit, 1'b0);
    check("R1", "ts after reset", ts_req, 1'b0);
    check("R1", "ready after reset", smp_ready, 1'b1);
  endtask

  task automatic t_zero_mask();
    logic t, p, s;
    send(BG, t, p, s);
    check("R4", "zero mask pattern match", p, 1'b1);
    check("R5", "zero mask first trigger", t, 1'b1);
    check("R9", "no ts when disabled", s, 1'b0);
    send(~BG, t, p, s);
    check("R6", "no refire while matching", t, 1'b0);
    check("R4", "zero mask second match", p, 1'b1);
  endtask

  task automatic t_trigger();
    logic t, p, s;
    wr(aw(0, 2), 32'h0000_1234);
    wr(aw(1, 2), 32'h0000_FFFF);
    send(BG, t, p, s);
    check("R5", "nonmatch no trigger", t, 1'b0);
    send(TRIG_HIT ^ (256'hFF << 200), t, p, s);
    check("R2", "word 2 trigger match", t, 1'b1);
    send(TRIG_HIT, t, p, s);
    check("R6", "held match no pulse", t, 1'b0);
    @(negedge clk);
    check("R10", "idle cycle trig", trig_pulse, 1'b0);
    check("R10", "idle cycle pat", pat_hit, 1'b0);
    send(TRIG_HIT, t, p, s);
    check("R6", "idle does not rearm", t, 1'b0);
    send(BG, t, p, s);
    check("R6", "lost match", t, 1'b0);
    send(BG | (256'h1234 << 160), t, p, s);
    check("R2", "value in wrong word", t, 1'b0);
    send(TRIG_HIT, t, p, s);
    check("R5", "refire after loss", t, 1'b1);
  endtask

  task automatic t_pat_value();
    logic t, p, s;
    wr(aw(2, 0), 32'h0000_00A5);
    wr(aw(3, 0), 32'h0000_00FF);
    send(BG | 256'hA5, t, p, s);
    check("R7", "value match", p, 1'b1);
    send(BG | 256'h5A, t, p, s);
    check("R7", "value mismatch", p, 1'b0);
    send(~BG & ~256'hFF | 256'hA5, t, p, s);
    check("R4", "unmasked bits ignored", p, 1'b1);
  endtask

  task automatic t_same_cycle_write();
    logic t, p, s;
    @(negedge clk) cfg_we = 1'b1; cfg_addr = aw(2, 0); cfg_wdata = 32'h3C;
    smp_valid = 1'b1; smp_data = BG | 256'hA5;
    @(negedge clk) cfg_we = 1'b0; smp_valid = 1'b0;
    check("R11", "old value used", pat_hit, 1'b1);
    send(BG | 256'hA5, t, p, s);
    check("R11", "old value gone", p, 1'b0);
    send(BG | 256'h3C, t, p, s);
    check("R11", "new value used", p, 1'b1);
  endtask

  task automatic t_toggle();
    logic t, p, s;
    wr(A_CTL, 32'h1);
    send(BG | 256'h11, t, p, s);
    send(BG | 256'h11, t, p, s);
    check("R8", "no change no hit", p, 1'b0);
    send(BG | 256'h10, t, p, s);
    check("R8", "masked bit flip hits", p, 1'b1);
    send(BG | 256'h10, t, p, s);
    check("R8", "steady after flip", p, 1'b0);
    send(BG | 256'h10 | (256'h1 << 40), t, p, s);
    check("R4", "unmasked flip ignored", p, 1'b0);
  endtask

  task automatic t_timestamp();
    logic t, p, s;
    wr(A_CTL, 32'h4);
    send(BG, t, p, s);
    send(TRIG_HIT, t, p, s);
    check("R9", "trigger fires", t, 1'b1);
    check("R9", "trigger ts", s, 1'b1);
    wr(A_CTL, 32'h2);
    send(BG | 256'h3C, t, p, s);
    check("R9", "pattern hit", p, 1'b1);
    check("R9", "pattern ts", s, 1'b1);
    wr(A_CTL, 32'h0);
    send(BG | 256'h3C, t, p, s);
    check("R3", "ts disabled", s, 1'b0);
  endtask

  task automatic t_toggle_first();
    logic t, p, s;
    do_reset();
    wr(A_CTL, 32'h1);
    wr(aw(3, 0), 32'h1);
    send(BG | 256'h1, t, p, s);
    check("R8", "first sample never hits", p, 1'b0);
    send(BG, t, p, s);
    check("R8", "second sample toggles", p, 1'b1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_zero_mask();
    t_trigger();
    t_pat_value();
    t_same_cycle_write();
    t_toggle();
    t_timestamp();
    t_toggle_first();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule